// File: doc/BRIEF.md
# Flash program/erase command controller

This block sits between a CPU and an on-chip flash array. Software sets a mode in a small control register and then writes a word into the flash address space. Depending on the mode, that write becomes a word program, an erase of the 512-word page that holds the word, or an erase of the whole block that holds the word. The block drives a single-command interface toward the array: a start pulse, an operation code, an address and data. The array answers with a done pulse and a fail flag, plus read-back data for verify reads.

A single-entry write buffer takes the request. A sequencer then issues one or two array commands for it. A block erase aimed at the information block erases that block and then the main block. A program, unless verify is disabled, is followed by a verify read whose data is compared against what was written. Errors are latched as sticky flags that are cleared by writing a one. A request made while the controller is occupied stalls the CPU. An optional interrupt reports that the buffer has been freed.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the control register (reg_addr_i=0) and the status register (reg_addr_i=1) read 0, and stall_o, irq_o and arr_start_o are low.
- R2: Control bits are program-enable bit 0, page-erase bit 1, block-erase bit 2, verify-disable bit 3 and interrupt-enable bit 4. With only program-enable set, a flash write issues a one-cycle arr_start_o with operation code 0 and the word's address and data.
- R3: With only page-erase set, a write to the main block issues operation code 1 at the address with its low 9 bits cleared.
- R4: With page-erase set, a write to the information block (word address 8192 to 8703) issues no command and sets no error flag.
- R5: With only block-erase set, a write to the main block (word address 0 to 8191) issues operation code 2 at address 0. A write to the information block issues operation code 2 at address 8192 and then operation code 2 at address 0.
- R6: A flash write is not acted on when zero or more than one of the three mode bits are set, or when its address is at or above 8704.
- R7: Status bit 0 is the erase error and bit 1 the program error. Writing 1 to either bit clears it. Writing 0 leaves it unchanged.
- R8: Status bit 2 (busy) is high while a command sequence runs. A valid write made while busy or full holds stall_o high, and the write is taken once both are low.
- R9: Status bit 3 (buffer full) is high for the cycle after a write is taken. It clears when the sequencer accepts the entry, and busy rises in that same cycle.
- R10: With interrupt-enable set, irq_o pulses for one cycle when buffer full falls. With interrupt-enable clear, irq_o stays low.
- R11: With verify-disable clear, a program that completes without failure is followed by operation code 3 at the same address. Read-back data that differs from the written word sets the program error. With verify-disable set, no verify command is issued.
- R12: A fail indication during a program or verify sets the program error. A fail indication during an erase sets the erase error.
- R13: Writes to control bits 0 to 3 are ignored while busy or full. Interrupt-enable stays writable at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 status |
| reg_wdata_i | input | 5 | Register write data |
| reg_rdata_o | output | 5 | Register read data for reg_addr_i |
| fl_we_i | input | 1 | CPU word write into flash space |
| fl_addr_i | input | 14 | Flash word address |
| fl_wdata_i | input | 16 | Flash write data |
| stall_o | output | 1 | Holds the CPU write until it can be taken |
| irq_o | output | 1 | Buffer-freed interrupt pulse |
| arr_start_o | output | 1 | Command start pulse to the array |
| arr_op_o | output | 2 | Operation: 0 program, 1 page erase, 2 block erase, 3 verify read |
| arr_addr_o | output | 14 | Command word address |
| arr_data_o | output | 16 | Program data, also the verify reference |
| arr_done_i | input | 1 | Command complete pulse |
| arr_fail_i | input | 1 | Command failed, valid with arr_done_i |
| arr_rdata_i | input | 16 | Verify read data, valid with arr_done_i |

## Verification
The assertions watch, on every cycle, the properties that hold at all times. Start is a one-cycle pulse that occurs only while busy. The buffer hands its entry to the sequencer after exactly one cycle. The interrupt appears only on a falling buffer-full edge with interrupt-enable set. The mode bits hold steady while busy, and the program error never drops without a write-one. The bench scenarios are the only evidence for what a given request turns into: the operation codes and addresses for page- and block-erase scope, the second command for information-block erase, the verify read and its comparison, the rejection of ambiguous modes and out-of-range addresses, and the stall-then-accept order.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_PAGE   = 2'd1,
    OP_BLOCK  = 2'd2,
    OP_VERIFY = 2'd3
  } fop_e;

  // control register, bit 0 at the bottom
  typedef struct packed {
    logic irq_en;
    logic vfy_dis;
    logic blk_en;
    logic page_en;
    logic prog_en;
  } ctrl_t;

  localparam int REG_W   = $bits(ctrl_t);
  localparam int ST_EERR = 0;
  localparam int ST_PERR = 1;
  localparam int ST_BUSY = 2;
  localparam int ST_FULL = 3;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int PAGE_WORDS = 512,
  parameter int MAIN_PAGES = 16,
  parameter int INFO_PAGES = 1,
  localparam int MAIN_WORDS = PAGE_WORDS * MAIN_PAGES,
  localparam int INFO_END   = MAIN_WORDS + PAGE_WORDS * INFO_PAGES,
  localparam int AW         = $clog2(INFO_END),
  localparam int PG_BITS    = $clog2(PAGE_WORDS)
) (
  input  logic          we_i,
  input  ctrl_t         ctrl_i,
  input  logic [AW-1:0] addr_i,
  output logic          act_o,
  output fop_e          op_o,
  output logic [AW-1:0] addr_o,
  output logic          two_step_o
);

  localparam logic [AW:0] MAIN_LIM = (AW+1)'(MAIN_WORDS);
  localparam logic [AW:0] INFO_LIM = (AW+1)'(INFO_END);

  logic in_main, in_info, one_mode;

  assign in_main  = {1'b0, addr_i} < MAIN_LIM;
  assign in_info  = !in_main && ({1'b0, addr_i} < INFO_LIM);
  assign one_mode = $countones({ctrl_i.prog_en, ctrl_i.page_en, ctrl_i.blk_en}) == 1;

  // page erase of the information block is dropped silently
  assign act_o = we_i && one_mode && (in_main || in_info) &&
                 !(ctrl_i.page_en && in_info);

  always_comb begin
    op_o       = OP_PROG;
    addr_o     = addr_i;
    two_step_o = 1'b0;
    if (ctrl_i.page_en) begin
      op_o   = OP_PAGE;
      addr_o = {addr_i[AW-1:PG_BITS], {PG_BITS{1'b0}}};
    end else if (ctrl_i.blk_en) begin
      op_o       = OP_BLOCK;
      addr_o     = in_info ? AW'(MAIN_WORDS) : '0;
      two_step_o = in_info;
    end
  end

endmodule

// File: rtl/flash_cmd_regs.sv
module flash_cmd_regs
  import flash_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             pend_i,
  input  logic             busy_i,
  input  logic             full_i,
  input  logic             set_perr_i,
  input  logic             set_eerr_i,
  output ctrl_t            ctrl_o,
  output logic             eerr_o,
  output logic             perr_o,
  output logic [REG_W-1:0] rdata_o,
  output logic             irq_o
);

  ctrl_t ctrl_q;
  logic  eerr_q, perr_q, full_q;
  logic  st_wr;

  assign st_wr = we_i && addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      eerr_q <= 1'b0;
      perr_q <= 1'b0;
      full_q <= 1'b0;
    end else begin
      if (we_i && !addr_i) begin
        ctrl_q.irq_en <= wdata_i[4];
        if (!pend_i) ctrl_q[3:0] <= wdata_i[3:0];
      end
      eerr_q <= set_eerr_i | (eerr_q & ~(st_wr & wdata_i[ST_EERR]));
      perr_q <= set_perr_i | (perr_q & ~(st_wr & wdata_i[ST_PERR]));
      full_q <= full_i;
    end
  end

  always_comb begin
    rdata_o = ctrl_q;
    if (addr_i) begin
      rdata_o          = '0;
      rdata_o[ST_EERR] = eerr_q;
      rdata_o[ST_PERR] = perr_q;
      rdata_o[ST_BUSY] = busy_i;
      rdata_o[ST_FULL] = full_i;
    end
  end

  assign ctrl_o = ctrl_q;
  assign eerr_o = eerr_q;
  assign perr_o = perr_q;
  assign irq_o  = ctrl_q.irq_en & full_q & ~full_i;

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int AW = 14,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  fop_e          op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          two_i,
  input  logic          vfy_i,
  input  logic          done_i,
  input  logic          fail_i,
  input  logic [DW-1:0] rdata_i,
  output logic          full_o,
  output logic          busy_o,
  output logic          start_o,
  output logic [1:0]    op_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          set_perr_o,
  output logic          set_eerr_o
);

  typedef enum logic {S_IDLE, S_WAIT} st_e;

  st_e           st_q;
  logic          buf_v, buf_two, buf_vfy;
  fop_e          buf_op, cur_op;
  logic [AW-1:0] buf_addr, cur_addr;
  logic [DW-1:0] buf_data, cur_data;
  logic          cur_two, cur_vfy, start_q;
  logic          fin, is_prog;

  // single-entry request buffer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_v    <= 1'b0;
      buf_op   <= OP_PROG;
      buf_addr <= '0;
      buf_data <= '0;
      buf_two  <= 1'b0;
      buf_vfy  <= 1'b0;
    end else if (acc_i) begin
      buf_v    <= 1'b1;
      buf_op   <= op_i;
      buf_addr <= addr_i;
      buf_data <= data_i;
      buf_two  <= two_i;
      buf_vfy  <= vfy_i;
    end else if (st_q == S_IDLE && buf_v) begin
      buf_v <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      cur_op   <= OP_PROG;
      cur_addr <= '0;
      cur_data <= '0;
      cur_two  <= 1'b0;
      cur_vfy  <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      start_q <= 1'b0;
      case (st_q)
        S_IDLE: if (buf_v) begin
          cur_op   <= buf_op;
          cur_addr <= buf_addr;
          cur_data <= buf_data;
          cur_two  <= buf_two;
          cur_vfy  <= buf_vfy;
          start_q  <= 1'b1;
          st_q     <= S_WAIT;
        end
        S_WAIT: if (done_i) begin
          if (cur_two) begin
            // information block done, main block follows
            cur_two  <= 1'b0;
            cur_addr <= '0;
            start_q  <= 1'b1;
          end else if (cur_op == OP_PROG && cur_vfy && !fail_i) begin
            cur_op  <= OP_VERIFY;
            start_q <= 1'b1;
          end else begin
            st_q <= S_IDLE;
          end
        end
      endcase
    end
  end

  assign fin        = (st_q == S_WAIT) && done_i;
  assign is_prog    = (cur_op == OP_PROG) || (cur_op == OP_VERIFY);
  assign set_perr_o = fin && is_prog &&
                      (fail_i || (cur_op == OP_VERIFY && rdata_i != cur_data));
  assign set_eerr_o = fin && !is_prog && fail_i;

  assign full_o  = buf_v;
  assign busy_o  = (st_q == S_WAIT);
  assign start_o = start_q;
  assign op_o    = cur_op;
  assign addr_o  = cur_addr;
  assign data_o  = cur_data;

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int PAGE_WORDS = 512,
  parameter int MAIN_PAGES = 16,
  parameter int INFO_PAGES = 1,
  parameter int DW         = 16,
  localparam int AW        = $clog2(PAGE_WORDS * (MAIN_PAGES + INFO_PAGES))
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic             reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             fl_we_i,
  input  logic [AW-1:0]    fl_addr_i,
  input  logic [DW-1:0]    fl_wdata_i,
  output logic             stall_o,
  output logic             irq_o,
  output logic             arr_start_o,
  output logic [1:0]       arr_op_o,
  output logic [AW-1:0]    arr_addr_o,
  output logic [DW-1:0]    arr_data_o,
  input  logic             arr_done_i,
  input  logic             arr_fail_i,
  input  logic [DW-1:0]    arr_rdata_i
);

  ctrl_t         ctrl_q;
  logic          busy, full, pend, req, acc;
  logic          set_perr, set_eerr, eerr, perr;
  fop_e          dec_op;
  logic [AW-1:0] dec_addr;
  logic          dec_two;

  assign pend    = busy | full;
  assign stall_o = req & pend;
  assign acc     = req & ~pend;

  flash_cmd_decode #(
    .PAGE_WORDS(PAGE_WORDS),
    .MAIN_PAGES(MAIN_PAGES),
    .INFO_PAGES(INFO_PAGES)
  ) u_dec (
    .we_i      (fl_we_i),
    .ctrl_i    (ctrl_q),
    .addr_i    (fl_addr_i),
    .act_o     (req),
    .op_o      (dec_op),
    .addr_o    (dec_addr),
    .two_step_o(dec_two)
  );

  flash_cmd_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .pend_i    (pend),
    .busy_i    (busy),
    .full_i    (full),
    .set_perr_i(set_perr),
    .set_eerr_i(set_eerr),
    .ctrl_o    (ctrl_q),
    .eerr_o    (eerr),
    .perr_o    (perr),
    .rdata_o   (reg_rdata_o),
    .irq_o     (irq_o)
  );

  flash_cmd_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (acc),
    .op_i      (dec_op),
    .addr_i    (dec_addr),
    .data_i    (fl_wdata_i),
    .two_i     (dec_two),
    .vfy_i     (~ctrl_q.vfy_dis),
    .done_i    (arr_done_i),
    .fail_i    (arr_fail_i),
    .rdata_i   (arr_rdata_i),
    .full_o    (full),
    .busy_o    (busy),
    .start_o   (arr_start_o),
    .op_o      (arr_op_o),
    .addr_o    (arr_addr_o),
    .data_o    (arr_data_o),
    .set_perr_o(set_perr),
    .set_eerr_o(set_eerr)
  );

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       arr_start_o,
  input logic       busy,
  input logic       full,
  input logic       irq_o,
  input logic       irq_en,
  input logic [3:0] mode,
  input logic       perr,
  input logic       reg_we_i,
  input logic       reg_addr_i,
  input logic       clr_perr
);

  assert_start_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_start_o |=> !arr_start_o);

  assert_start_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_start_o |-> busy);

  assert_full_handoff_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full |=> (!full && busy));

  assert_irq_edge_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(full) && !full && irq_en));

  assert_mode_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy) |-> (mode == $past(mode)));

  assert_perr_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(perr) && !$past(reg_we_i && reg_addr_i && clr_perr)) |-> perr);

endmodule

bind flash_cmd_ctrl flash_cmd_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .arr_start_o(arr_start_o),
  .busy       (busy),
  .full       (full),
  .irq_o      (irq_o),
  .irq_en     (ctrl_q.irq_en),
  .mode       (ctrl_q[3:0]),
  .perr       (perr),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .clr_perr   (reg_wdata_i[1])
);

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;

  localparam int AW = 14;
  localparam int DW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we_i = 1'b0;
  logic          reg_addr_i = 1'b0;
  logic [4:0]    reg_wdata_i = '0;
  logic [4:0]    reg_rdata_o;
  logic          fl_we_i = 1'b0;
  logic [AW-1:0] fl_addr_i = '0;
  logic [DW-1:0] fl_wdata_i = '0;
  logic          stall_o, irq_o, arr_start_o;
  logic [1:0]    arr_op_o;
  logic [AW-1:0] arr_addr_o;
  logic [DW-1:0] arr_data_o;
  logic          arr_done_i = 1'b0;
  logic          arr_fail_i = 1'b0;
  logic [DW-1:0] arr_rdata_i = '0;

  flash_cmd_ctrl uut (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  int cmd_cnt = 0, irq_cnt = 0;
  int resp_delay = 3;
  logic cur_fail = 1'b0, cur_bad = 1'b0, finished = 1'b0;
  logic [1:0]    c_op   [4];
  logic [AW-1:0] c_addr [4];
  logic [DW-1:0] c_data [4];
  logic [4:0]    rv;

  typedef struct packed {
    logic [4:0]    ctrl;
    logic [AW-1:0] addr;
    logic          fail;
    logic          bad;
    logic [1:0]    n;
    logic [1:0]    op0;
    logic [AW-1:0] a0;
    logic [1:0]    op1;
    logic [AW-1:0] a1;
    logic [1:0]    err;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{5'h11, 14'd100,  1'b0, 1'b0, 2'd2, 2'd0, 14'd100,  2'd3, 14'd100, 2'd0}, // R2 R11
    '{5'h09, 14'd100,  1'b0, 1'b0, 2'd1, 2'd0, 14'd100,  2'd0, 14'd0,   2'd0}, // R11 skip
    '{5'h01, 14'd300,  1'b0, 1'b1, 2'd2, 2'd0, 14'd300,  2'd3, 14'd300, 2'd2}, // R11 mismatch
    '{5'h01, 14'd300,  1'b1, 1'b0, 2'd1, 2'd0, 14'd300,  2'd0, 14'd0,   2'd2}, // R12
    '{5'h02, 14'd1234, 1'b0, 1'b0, 2'd1, 2'd1, 14'd1024, 2'd0, 14'd0,   2'd0}, // R3
    '{5'h02, 14'd8300, 1'b0, 1'b0, 2'd0, 2'd0, 14'd0,    2'd0, 14'd0,   2'd0}, // R4
    '{5'h14, 14'd5000, 1'b0, 1'b0, 2'd1, 2'd2, 14'd0,    2'd0, 14'd0,   2'd0}, // R5
    '{5'h04, 14'd8200, 1'b0, 1'b0, 2'd2, 2'd2, 14'd8192, 2'd2, 14'd0,   2'd0}, // R5 info
    '{5'h04, 14'd5000, 1'b1, 1'b0, 2'd1, 2'd2, 14'd0,    2'd0, 14'd0,   2'd1}, // R12
    '{5'h03, 14'd100,  1'b0, 1'b0, 2'd0, 2'd0, 14'd0,    2'd0, 14'd0,   2'd0}, // R6
    '{5'h00, 14'd100,  1'b0, 1'b0, 2'd0, 2'd0, 14'd0,    2'd0, 14'd0,   2'd0}, // R6
    '{5'h01, 14'd9000, 1'b0, 1'b0, 2'd0, 2'd0, 14'd0,    2'd0, 14'd0,   2'd0}, // R6 range
    '{5'h04, 14'd8700, 1'b1, 1'b0, 2'd2, 2'd2, 14'd8192, 2'd2, 14'd0,   2'd1}, // R5 R12
    '{5'h12, 14'd8191, 1'b0, 1'b0, 2'd1, 2'd1, 14'd7680, 2'd0, 14'd0,   2'd0}, // R3 R10
    '{5'h07, 14'd100,  1'b0, 1'b0, 2'd0, 2'd0, 14'd0,    2'd0, 14'd0,   2'd0}  // R6
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic a, input logic [4:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_rd(input logic a, output logic [4:0] v);
    reg_addr_i = a;
    #1 v = reg_rdata_o;
  endtask

  task automatic fl_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk_i);
    fl_we_i = 1'b1; fl_addr_i = a; fl_wdata_i = d;
    #1;
    while (stall_o) begin @(negedge clk_i); #1; end
    @(negedge clk_i);
    fl_we_i = 1'b0;
  endtask

  // array model
  initial begin
    forever begin
      @(negedge clk_i);
      while (arr_start_o) begin
        if (cmd_cnt < 4) begin
          c_op[cmd_cnt]   = arr_op_o;
          c_addr[cmd_cnt] = arr_addr_o;
          c_data[cmd_cnt] = arr_data_o;
        end
        cmd_cnt++;
        repeat (resp_delay - 1) @(negedge clk_i);
        arr_done_i  = 1'b1;
        arr_fail_i  = cur_fail;
        arr_rdata_i = arr_data_o ^ (cur_bad ? 16'h0001 : 16'h0000);
        @(negedge clk_i);
        arr_done_i = 1'b0;
        arr_fail_i = 1'b0;
      end
    end
  end

  initial forever begin
    @(negedge clk_i);
    if (irq_o) irq_cnt++;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk_i);
    reg_rd(1'b0, rv); chk("R1 ctrl", rv, 0);
    reg_rd(1'b1, rv); chk("R1 status", rv, 0);
    chk("R1 stall", stall_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 start", arr_start_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // vector table
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      cur_fail = v.fail; cur_bad = v.bad;
      reg_wr(1'b0, v.ctrl);
      cmd_cnt = 0; irq_cnt = 0;
      fl_wr(v.addr, 16'(16'hA500 + i));
      repeat (30) @(negedge clk_i);
      chk($sformatf("R6 count v%0d", i), cmd_cnt, 32'(v.n));
      if (v.n >= 1) begin
        chk($sformatf("R5 op0 v%0d", i), c_op[0], v.op0);
        chk($sformatf("R3 addr0 v%0d", i), c_addr[0], v.a0);
        if (v.op0 == 2'd0) chk($sformatf("R2 data v%0d", i), c_data[0], 16'(16'hA500 + i));
      end
      if (v.n >= 2) begin
        chk($sformatf("R11 op1 v%0d", i), c_op[1], v.op1);
        chk($sformatf("R5 addr1 v%0d", i), c_addr[1], v.a1);
      end
      reg_rd(1'b1, rv);
      chk($sformatf("R12 err v%0d", i), rv[1:0], v.err);
      chk($sformatf("R4 idle v%0d", i), rv[3:2], 0);
      chk($sformatf("R10 irq v%0d", i), irq_cnt, (v.ctrl[4] && v.n != 0) ? 1 : 0);
      reg_wr(1'b1, 5'h03);
    end
    cur_fail = 1'b0; cur_bad = 1'b0;

    // R9 full then busy
    reg_wr(1'b0, 5'h09);
    cmd_cnt = 0;
    @(negedge clk_i);
    fl_we_i = 1'b1; fl_addr_i = 14'd50; fl_wdata_i = 16'h0F0F; reg_addr_i = 1'b1;
    @(negedge clk_i);
    fl_we_i = 1'b0;
    #1 chk("R9 full", reg_rdata_o, 5'h08);
    @(negedge clk_i);
    #1 chk("R8 busy", reg_rdata_o, 5'h04);
    repeat (20) @(negedge clk_i);

    // R7 write-one-to-clear
    cur_fail = 1'b1;
    fl_wr(14'd60, 16'h1111);
    repeat (20) @(negedge clk_i);
    reg_wr(1'b1, 5'h00); reg_rd(1'b1, rv); chk("R7 zero keeps perr", rv, 5'h02);
    reg_wr(1'b1, 5'h01); reg_rd(1'b1, rv); chk("R7 other bit keeps perr", rv, 5'h02);
    reg_wr(1'b1, 5'h02); reg_rd(1'b1, rv); chk("R7 perr cleared", rv, 5'h00);
    reg_wr(1'b0, 5'h04);
    fl_wr(14'd60, 16'h1111);
    repeat (20) @(negedge clk_i);
    reg_wr(1'b1, 5'h02); reg_rd(1'b1, rv); chk("R7 keeps eerr", rv, 5'h01);
    reg_wr(1'b1, 5'h01); reg_rd(1'b1, rv); chk("R7 eerr cleared", rv, 5'h00);
    cur_fail = 1'b0;

    // R8 stall and R13 mode hold
    resp_delay = 10;
    reg_wr(1'b0, 5'h09);
    cmd_cnt = 0; irq_cnt = 0;
    fl_wr(14'd100, 16'h2222);
    @(negedge clk_i);
    fl_we_i = 1'b1; fl_addr_i = 14'd200; fl_wdata_i = 16'h1234;
    #1 chk("R8 stall while busy", stall_o, 1);
    reg_wr(1'b0, 5'h02);
    reg_rd(1'b0, rv); chk("R13 mode held", rv, 5'h09);
    reg_wr(1'b0, 5'h19);
    reg_rd(1'b0, rv); chk("R13 irq_en writable", rv, 5'h19);
    #1 chk("R8 still stalled", stall_o, 1);
    while (stall_o) begin @(negedge clk_i); #1; end
    @(negedge clk_i);
    fl_we_i = 1'b0;
    repeat (40) @(negedge clk_i);
    chk("R8 both taken", cmd_cnt, 2);
    chk("R8 second addr", c_addr[1], 14'd200);
    chk("R8 second data", c_data[1], 16'h1234);
    chk("R10 irq on second", irq_cnt, 1);
    chk("R8 stall released", stall_o, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule